// File: doc/BRIEF.md
# Third-Order Noise-Shaped Division Ratio Sequencer

This block turns a static integer division ratio and a 10-bit fraction into a stream of per-period control codes for a multi-modulus feedback divider. Over time, the average division ratio then equals the integer plus the fraction divided by 1024. It is clocked by the divided reference and issues one new code every divided period. Three first-order accumulators are cascaded. Each accumulator adds in one cycle with a 10-bit ripple adder. The carry bit each stage produces is kept inside that stage's own state register. Each later stage adds the registered residue of the stage before it. The carries are combined into a signed offset by a cancellation network: the first stage's carry passes straight through, the second stage's carry is differenced once, and the third stage's carry is differenced twice. Short carry history chains line the three stages up in time.

The offset is added to the integer ratio, limited to the legal range 20 to 43, and mapped onto the 5-bit code that the divider decodes. When the enable is low, the modulator is held idle with every accumulator and history bit at zero. In that state the integer ratio passes through alone, so an integer-only synthesizer sees a constant code. Each new enable therefore starts the sequence from a known all-zero state.

Top module: `mash_frac_modulator`

## Requirements
- R1: The output code maps ratio r to r−16 for r in 20..31 and to r−12 for r in 32..43, so only codes 4..15 and 20..31 ever appear.
- R2: The code is registered. Reset gives code 4 (ratio 20). Each rising edge loads the code for the inputs sampled at that edge, and the output does not change between edges.
- R3: While frac_en is low, the ratio equals the limited int_ratio, and frac_word has no effect on the output.
- R4: The ratio is limited to 20..43: sums below 20 give 20 and sums above 43 give 43. This also applies to out-of-range int_ratio values.
- R5: While enabled, the ratio minus int_ratio stays within −3..+4 whenever no limiting occurs.
- R6: While frac_en is low, all accumulators and history bits are held at zero. The first three outputs of any enabled run therefore carry zero offset.
- R7: With a constant fraction f, the sum of the offsets over any 8192 consecutive enabled outputs is within 4 of 8·f.
- R8: With frac_word zero from the start of an enabled run, the offset is always zero.
- R9: Each new enabled run with the same inputs repeats exactly the same code sequence.
- R10: Stage residues update as s1←s1+f, s2←s2+s1, s3←s3+s2 (mod 1024, using the previous values), with carries k1, k2, k3. The offset is k1[n−2]+k2[n−1]−k2[n−2]+k3[n]−2·k3[n−1]+k3[n−2], using the carries held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided reference clock |
| rst | input | 1 | Synchronous active-high reset |
| frac_en | input | 1 | High: fractional operation; low: idle, integer pass-through |
| int_ratio | input | 6 | Integer division ratio |
| frac_word | input | FRAC_W (10) | Fraction numerator over 1024 |
| ctrl_code | output | 5 | Registered divider control code |

## Verification
The properties check, on every cycle, the properties that depend only on recent inputs. These are: the legal code set, the pass-through while idle, the −3..+4 offset bound, and the zero offset during the first three cycles after enable. Properties that depend on the whole history can only be shown by the bench scenarios. These are: the long-run average over 8192 cycles, the exact cycle-by-cycle cancellation sequence, the repeat on re-enable, and the zero offset with a zero fraction. The bench checks them against its behavioural model and its window sums.

// File: rtl/mash_frac_pkg.sv
package mash_frac_pkg;

    localparam int RATIO_W    = 6;
    localparam int CODE_W     = 5;
    localparam int OFS_W      = 4;
    localparam int RATIO_MIN  = 20;
    localparam int RATIO_MAX  = 43;
    localparam int SPLIT      = 32;
    localparam int LOW_BIAS   = 16;
    localparam int HIGH_BIAS  = 12;
    localparam int ORDER      = 3;

    typedef logic signed [OFS_W-1:0] offset_t;
    typedef logic [CODE_W-1:0]       code_t;

    typedef struct packed {
        logic               high_group;
        logic [RATIO_W-1:0] ratio;
    } ratio_sel_t;

    function automatic int clamp_ratio(input int r);
        if (r < RATIO_MIN)      return RATIO_MIN;
        else if (r > RATIO_MAX) return RATIO_MAX;
        else                    return r;
    endfunction

    function automatic int code_to_ratio(input code_t c);
        if (int'(c) >= SPLIT - HIGH_BIAS) return int'(c) + HIGH_BIAS;
        else                              return int'(c) + LOW_BIAS;
    endfunction

    function automatic logic code_is_legal(input code_t c);
        return (int'(c) >= RATIO_MIN - LOW_BIAS && int'(c) <= SPLIT - 1 - LOW_BIAS) ||
               (int'(c) >= SPLIT - HIGH_BIAS && int'(c) <= RATIO_MAX - HIGH_BIAS);
    endfunction

endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] addend,
    output logic [W-1:0] residue,
    output logic         carry
);
    logic [W:0] sum_next;

    assign sum_next = {1'b0, residue} + {1'b0, addend};

    // carry lives in the same register as the residue
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            residue <= '0;
            carry   <= 1'b0;
        end else begin
            residue <= sum_next[W-1:0];
            carry   <= sum_next[W];
        end
    end
endmodule

// File: rtl/mash_noise_cancel.sv
module mash_noise_cancel
    import mash_frac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [ORDER-1:0] carry,
    output offset_t          offset
);
    logic [ORDER-1:0] hist1;
    logic [ORDER-1:0] hist2;
    int               combined;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hist1 <= '0;
            hist2 <= '0;
        end else begin
            hist1 <= carry;
            hist2 <= hist1;
        end
    end

    // stage 1 delayed twice, stage 2 differenced once, stage 3 twice
    always_comb begin
        combined = int'(hist2[0])
                 + int'(hist1[1]) - int'(hist2[1])
                 + int'(carry[2]) - 2 * int'(hist1[2]) + int'(hist2[2]);
        offset = clear ? offset_t'(0) : offset_t'(combined);
    end
endmodule

// File: rtl/mash_ratio_encoder.sv
module mash_ratio_encoder
    import mash_frac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] int_ratio,
    input  offset_t            offset,
    output code_t              code
);
    int         raw_sum;
    ratio_sel_t sel;
    code_t      code_next;

    always_comb begin
        raw_sum        = int'(int_ratio) + int'(offset);
        sel.ratio      = RATIO_W'(clamp_ratio(raw_sum));
        sel.high_group = int'(sel.ratio) >= SPLIT;
        if (sel.high_group)
            code_next = CODE_W'(int'(sel.ratio) - HIGH_BIAS);
        else
            code_next = CODE_W'(int'(sel.ratio) - LOW_BIAS);
    end

    always_ff @(posedge clk) begin
        if (rst) code <= CODE_W'(RATIO_MIN - LOW_BIAS);
        else     code <= code_next;
    end
endmodule

// File: rtl/mash_frac_modulator.sv
module mash_frac_modulator
    import mash_frac_pkg::*;
#(
    parameter int FRAC_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frac_en,
    input  logic [5:0]         int_ratio,
    input  logic [FRAC_W-1:0]  frac_word,
    output logic [4:0]         ctrl_code
);
    logic              idle;
    logic [FRAC_W-1:0] residue [ORDER];
    logic [FRAC_W-1:0] addend  [ORDER];
    logic [ORDER-1:0]  carry;
    offset_t           offset;
    code_t             code;

    assign idle = !frac_en;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign addend[g] = frac_word;
        end else begin : g_chain
            assign addend[g] = residue[g-1];
        end
        mash_acc_stage #(.W(FRAC_W)) i_acc (
            .clk     (clk),
            .rst     (rst),
            .clear   (idle),
            .addend  (addend[g]),
            .residue (residue[g]),
            .carry   (carry[g])
        );
    end

    mash_noise_cancel i_cancel (
        .clk    (clk),
        .rst    (rst),
        .clear  (idle),
        .carry  (carry),
        .offset (offset)
    );

    mash_ratio_encoder i_enc (
        .clk       (clk),
        .rst       (rst),
        .int_ratio (int_ratio),
        .offset    (offset),
        .code      (code)
    );

    assign ctrl_code = code;
endmodule

// File: rtl/mash_frac_modulator_chk.sv
module mash_frac_modulator_chk
    import mash_frac_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frac_en,
    input logic [5:0] int_ratio,
    input logic [4:0] ctrl_code
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)          age <= '0;
        else if (age < 4) age <= age + 3'd1;
    end

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        code_is_legal(ctrl_code)); // R1

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (age >= 1 && !$past(frac_en))
        |-> code_to_ratio(ctrl_code) == clamp_ratio(int'($past(int_ratio)))); // R3

    AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (rst)
        (age >= 1 && $past(frac_en) && $past(int_ratio) >= 23 && $past(int_ratio) <= 39)
        |-> (code_to_ratio(ctrl_code) - int'($past(int_ratio)) >= -3 &&
             code_to_ratio(ctrl_code) - int'($past(int_ratio)) <= 4)); // R5

    AST_STARTUP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (age >= 4 && $past(frac_en) && !$past(frac_en, 4))
        |-> code_to_ratio(ctrl_code) == clamp_ratio(int'($past(int_ratio)))); // R6
endmodule

bind mash_frac_modulator mash_frac_modulator_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .frac_en   (frac_en),
    .int_ratio (int_ratio),
    .ctrl_code (ctrl_code)
);

// File: tb/test_mash_frac_modulator.sv
`timescale 1ns/1ps
module test_mash_frac_modulator;
    localparam int PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frac_en = 1'b0;
    logic [5:0] int_ratio = 6'd30;
    logic [9:0] frac_word = '0;
    logic [4:0] ctrl_code;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 0;
    bit done = 0;

    int m_res [3];
    int m_car [3][3];
    int exp_code = 4;

    int first_run [20];

    always #(PERIOD/2) clk = ~clk;

    mash_frac_modulator i_mash_frac_modulator (
        .clk(clk), .rst(rst), .frac_en(frac_en),
        .int_ratio(int_ratio), .frac_word(frac_word), .ctrl_code(ctrl_code)
    );

    function automatic int lim(input int r);
        return (r < 20) ? 20 : ((r > 43) ? 43 : r);
    endfunction
    function automatic int enc(input int r);
        return (r >= 32) ? r - 12 : r - 16;
    endfunction
    function automatic int dec(input int c);
        return (c >= 20) ? c + 12 : c + 16;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // behavioural model of the offset sequence (R10)
    always @(posedge clk) begin
        int y, n0, n1, n2;
        if (rst) begin
            for (int s = 0; s < 3; s++) begin
                m_res[s] = 0;
                for (int a = 0; a < 3; a++) m_car[s][a] = 0;
            end
            exp_code = enc(20);
        end else begin
            y = 0;
            if (frac_en)
                y = m_car[0][2] + m_car[1][1] - m_car[1][2]
                  + m_car[2][0] - 2 * m_car[2][1] + m_car[2][2];
            exp_code = enc(lim(int'(int_ratio) + y));
            if (!frac_en) begin
                for (int s = 0; s < 3; s++) begin
                    m_res[s] = 0;
                    for (int a = 0; a < 3; a++) m_car[s][a] = 0;
                end
            end else begin
                for (int s = 0; s < 3; s++) begin
                    m_car[s][2] = m_car[s][1];
                    m_car[s][1] = m_car[s][0];
                end
                n0 = m_res[0] + int'(frac_word);
                n1 = m_res[1] + m_res[0];
                n2 = m_res[2] + m_res[1];
                m_car[0][0] = n0 / 1024; m_res[0] = n0 % 1024;
                m_car[1][0] = n1 / 1024; m_res[1] = n1 % 1024;
                m_car[2][0] = n2 / 1024; m_res[2] = n2 % 1024;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on)
            check(int'(ctrl_code) == exp_code, "R10 cycle model", int'(ctrl_code), exp_code);
    end

    initial begin
        #(PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired requirement=all actual=hung expected=finished");
        report();
    end

    task automatic drive(input bit en, input int ir, input int fw);
        frac_en = en; int_ratio = 6'(ir); frac_word = 10'(fw);
    endtask

    initial begin
        int sum, r;
        repeat (3) @(negedge clk);
        check(ctrl_code == 5'd4, "R2 reset code", int'(ctrl_code), 4);
        rst = 1'b0;
        drive(0, 25, 300);
        cmp_on = 1;
        @(negedge clk);
        check(ctrl_code == 5'd9, "R1 low group", int'(ctrl_code), 9);
        drive(0, 37, 500);
        #1 check(ctrl_code == 5'd9, "R2 held between edges", int'(ctrl_code), 9);
        @(negedge clk);
        check(ctrl_code == 5'd25, "R1 high group", int'(ctrl_code), 25);
        drive(0, 10, 0);
        @(negedge clk);
        check(ctrl_code == 5'd4, "R4 low limit", int'(ctrl_code), 4);
        drive(0, 60, 0);
        @(negedge clk);
        check(ctrl_code == 5'd31, "R4 high limit", int'(ctrl_code), 31);
        for (int i = 0; i < 3; i++) begin
            drive(0, 33, 1023 - 400 * i);
            @(negedge clk);
            check(ctrl_code == 5'd21, "R3 fraction ignored", int'(ctrl_code), 21);
        end

        // first enabled run
        drive(1, 30, 700);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            first_run[i] = int'(ctrl_code);
            if (i < 3) check(dec(int'(ctrl_code)) == 30, "R6 startup zero", dec(int'(ctrl_code)), 30);
        end
        sum = 0;
        for (int i = 0; i < 8192; i++) begin
            @(negedge clk);
            r = dec(int'(ctrl_code)) - 30;
            sum += r;
            if (r < -3 || r > 4) check(0, "R5 offset range", r, 0);
        end
        check(sum >= 8 * 700 - 4 && sum <= 8 * 700 + 4, "R7 long-run average", sum, 8 * 700);
        check(1, "R5 offset range", 0, 0);

        // restart
        drive(0, 30, 700);
        repeat (2) @(negedge clk);
        drive(1, 30, 700);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(int'(ctrl_code) == first_run[i], "R9 repeat on re-enable", int'(ctrl_code), first_run[i]);
        end

        // zero fraction
        drive(0, 27, 0);
        repeat (2) @(negedge clk);
        drive(1, 27, 0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (dec(int'(ctrl_code)) != 27) check(0, "R8 zero fraction", dec(int'(ctrl_code)), 27);
        end
        check(dec(int'(ctrl_code)) == 27, "R8 zero fraction", dec(int'(ctrl_code)), 27);

        // limiting at both ends while enabled
        drive(0, 20, 1000);
        repeat (2) @(negedge clk);
        drive(1, 20, 1000);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (dec(int'(ctrl_code)) < 20) check(0, "R4 enabled low limit", dec(int'(ctrl_code)), 20);
        end
        drive(0, 43, 24);
        repeat (2) @(negedge clk);
        drive(1, 43, 24);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (dec(int'(ctrl_code)) > 43) check(0, "R4 enabled high limit", dec(int'(ctrl_code)), 43);
        end
        check(dec(int'(ctrl_code)) <= 43, "R4 enabled high limit", dec(int'(ctrl_code)), 43);

        cmp_on = 0;
        report();
    end
endmodule